// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Port Slave

This block is the digital front end of a multi-channel delta-sigma converter when the host supplies the serial clock. It watches a chip-select line (`cs_n`), a serial clock (`sck`) and a serial data input (`sdi`), and drives a serial data output (`sdo`) that floats whenever the device is not selected. Internally it cycles through three phases: converting, asleep with a result waiting, and a data exchange in which a 24-bit result frame goes out while a 16-bit command word comes in.

The converter is represented by a stub with a programmable busy time. When the stub finishes, it latches the `conv_word` input as the conversion result. The command word carries a channel byte and a configuration byte. How much of it is kept depends on how far the frame got before chip select went high again. The settings that are kept become active for the conversion that the end of the frame starts. A falling edge of chip select also samples `sck` to detect a host that wants internal-clock operation.

All pins are sampled by the block clock `clk`, so `sck` must be several times slower than `clk`.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset the block is converting, the applied channel and configuration bytes are both 0x00, the internal-clock flag is 0, and `sdo` is high-impedance while `cs_n` is high.
- R2: `sdo` is high-impedance whenever `cs_n` is high. While `cs_n` is low and a conversion is running, `sdo` is 1.
- R3: A conversion lasts CONV_CYCLES clock cycles, after which the block sleeps and `sdo` reads 0 with `cs_n` low. The result stays unchanged, even across toggles of `cs_n` and changes of `conv_word`, until the first `sck` rising edge seen with `cs_n` low.
- R4: The output frame is 24 bits. Bit 1 is the end-of-conversion flag (0), bit 2 is a constant 0, and bits 3 to 24 are `conv_word` MSB first (its MSB is the sign). A new bit appears on every `sck` falling edge.
- R5: `sdi` is sampled on each `sck` rising edge of the frame, starting with the first. The first 16 bits form the command word, MSB first. Bits 15:14 are a prefix, bit 13 is an enable, bits 15:8 are the channel byte and bits 7:0 are the configuration byte. Bits after the 16th are ignored.
- R6: The 24th `sck` falling edge ends the frame, starts a conversion at once (`sdo` returns to 1 while `cs_n` stays low), and commits both bytes.
- R7: A rising edge of `cs_n` during a frame aborts it and starts a conversion at once. If fewer than 8 falling edges have occurred, nothing is committed.
- R8: An abort after 8 to 15 falling edges commits the channel byte only.
- R9: An abort after 16 or more falling edges commits both bytes.
- R10: A command is committed only when its prefix is binary 10 and its enable bit is 1. Otherwise the previous settings are kept.
- R11: On every falling edge of `cs_n`, the internal-clock flag takes the level of `sck`: 1 if high, 0 if low.
- R12: `sck` edges during a conversion neither shift the result nor capture command bits.
- R13: The applied settings change only at the moment a frame ends and starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data in |
| conv_word | input | RES_W | Value the converter stub latches as its result |
| sdo | output | 1 | Serial data out, high-impedance when deselected |
| act_chan | output | 8 | Channel byte applied to the running conversion |
| act_cfg | output | 8 | Configuration byte applied to the running conversion |
| int_clk_sel | output | 1 | Set when `sck` was high at the last `cs_n` fall |

## Verification
Some behaviours are checked by the assertions on every cycle. A data frame is only ever open while the converter is idle. A frame end, full or aborted, puts the block straight back into a conversion. A finished conversion always leads into sleep. The applied settings never move outside a frame end. The falling-edge and command-bit counters stay in range. Other behaviours only the bench scenarios can show: the exact frame contents, the 7/8/15/16 abort boundaries that decide what is committed, rejection of malformed commands, holding the result across chip-select toggles, and the clock-mode sampling on a falling edge of chip select.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    localparam int CMD_W     = 16;
    localparam int FIELD_W   = 8;
    localparam int CHAN_GATE = 8;
    localparam int CFG_GATE  = 16;

    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_IO    = 2'd2
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] chan;
        logic [FIELD_W-1:0] cfg;
    } settings_t;

    typedef struct packed {
        logic take_chan;
        logic take_cfg;
    } commit_t;

    function automatic logic cmd_valid(input logic [CMD_W-1:0] w);
        return (w[CMD_W-1:CMD_W-2] == 2'b10) && w[CMD_W-3];
    endfunction

    function automatic commit_t commit_plan(input logic [7:0] falls,
                                            input logic [CMD_W-1:0] w);
        commit_t c;
        c.take_chan = cmd_valid(w) && (falls >= 8'(CHAN_GATE));
        c.take_cfg  = cmd_valid(w) && (falls >= 8'(CFG_GATE));
        return c;
    endfunction

endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int CONV_CYCLES = 200,
    parameter int RES_W       = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic             ready,
    output logic [RES_W-1:0] result
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          done;

    assign done = busy && (cnt == CW'(CONV_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b1;
            cnt    <= '0;
            ready  <= 1'b0;
            result <= '0;
        end else begin
            ready <= done;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (done) begin
                busy   <= 1'b0;
                result <= sample_in;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(CONV_CYCLES)));

    // R3
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> !busy);

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/adc_sp_outshift.sv
module adc_sp_outshift #(
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    input  logic               restart,
    output logic               head,
    output logic [CNT_W-1:0]   falls
);
    logic [FRAME_W-1:0] sreg;

    assign head = sreg[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            falls <= '0;
        end else if (load) begin
            sreg  <= load_word;
            falls <= '0;
        end else if (restart) begin
            falls <= '0;
        end else if (shift) begin
            sreg  <= {sreg[FRAME_W-2:0], 1'b1};
            falls <= falls + 1'b1;
        end
    end

    // R4
    falls_range_chk: assert property (@(posedge clk) disable iff (rst)
        falls <= CNT_W'(FRAME_W - 1));

    // R12
    load_vs_shift_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !shift);

endmodule

// File: rtl/adc_sp_cmdcap.sv
module adc_sp_cmdcap #(
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic             bit_in,
    output logic [CMD_W-1:0] word
);
    localparam int IW = $clog2(CMD_W + 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
            cnt  <= '0;
        end else if (sample && (cnt < IW'(CMD_W))) begin
            for (int i = 0; i < CMD_W; i++) begin
                if (cnt == IW'(CMD_W - 1 - i)) word[i] <= bit_in;
            end
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    cmd_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= IW'(CMD_W));

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
    import adc_sp_pkg::*;
#(
    parameter int RES_W       = 22,
    parameter int CONV_CYCLES = 200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               sdi,
    input  logic [RES_W-1:0]   conv_word,
    output logic               sdo,
    output logic [FIELD_W-1:0] act_chan,
    output logic [FIELD_W-1:0] act_cfg,
    output logic               int_clk_sel
);
    localparam int FRAME_W = RES_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    phase_e             phase;
    settings_t          applied;
    logic               cs_q, sck_q;
    logic               cs_fall, cs_rise, sck_rise, sck_fall;
    logic               busy, ready;
    logic [RES_W-1:0]   result;
    logic               head;
    logic [CNT_W-1:0]   falls;
    logic [CMD_W-1:0]   cmd_word;
    logic               frame_full, frame_abort, frame_end;
    logic [7:0]         fall_total;
    commit_t            plan;
    logic               sdo_d;

    assign cs_fall  = cs_q && !cs_n;
    assign cs_rise  = !cs_q && cs_n;
    assign sck_rise = !sck_q && sck && !cs_n;
    assign sck_fall = sck_q && !sck && !cs_n;

    assign frame_full  = (phase == PH_IO) && sck_fall && (falls == CNT_W'(FRAME_W - 1));
    assign frame_abort = (phase == PH_IO) && cs_rise;
    assign frame_end   = frame_full || frame_abort;
    assign fall_total  = frame_full ? 8'(FRAME_W) : 8'(falls);
    assign plan        = commit_plan(fall_total, cmd_word);

    adc_conv_stub #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) conv_i (
        .clk(clk), .rst(rst), .start(frame_end), .sample_in(conv_word),
        .busy(busy), .ready(ready), .result(result)
    );

    adc_sp_outshift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) out_i (
        .clk(clk), .rst(rst), .load(ready), .load_word({2'b00, result}),
        .shift(sck_fall && (phase == PH_IO)), .restart(frame_end),
        .head(head), .falls(falls)
    );

    adc_sp_cmdcap #(.CMD_W(CMD_W)) cmd_i (
        .clk(clk), .rst(rst), .clear(frame_end),
        .sample(sck_rise && (phase != PH_CONV)), .bit_in(sdi), .word(cmd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q        <= 1'b1;
            sck_q       <= 1'b0;
            phase       <= PH_CONV;
            applied     <= '0;
            int_clk_sel <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            if (cs_fall) int_clk_sel <= sck;
            unique case (phase)
                PH_CONV:  if (ready) phase <= PH_SLEEP;
                PH_SLEEP: if (sck_rise) phase <= PH_IO;
                PH_IO:    if (frame_end) phase <= PH_CONV;
                default:  phase <= PH_CONV;
            endcase
            if (frame_end) begin
                if (plan.take_chan) applied.chan <= cmd_word[CMD_W-1 -: FIELD_W];
                if (plan.take_cfg)  applied.cfg  <= cmd_word[FIELD_W-1:0];
            end
        end
    end

    assign act_chan = applied.chan;
    assign act_cfg  = applied.cfg;
    assign sdo_d    = (phase == PH_CONV) ? 1'b1 : head;
    assign sdo      = cs_n ? 1'bz : sdo_d;

    // R6
    end_converts_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (phase == PH_CONV) && busy);

    // R3
    ready_sleeps_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> (phase == PH_SLEEP));

    // R12
    io_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IO) |-> !busy);

    // R13
    settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(applied) |-> $past(frame_end));

endmodule

// File: tb/adc_serial_slave_tb.sv
module adc_serial_slave_tb_top;

    localparam int RES_W = 22;
    localparam int CONV  = 100;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1;
    logic             sck = 1'b0;
    logic             sdi = 1'b0;
    logic [RES_W-1:0] conv_word = 22'h25A3C1;
    logic             sdo;
    logic [7:0]       act_chan, act_cfg;
    logic             int_clk_sel;

    int checks = 0;
    int errors = 0;

    localparam logic [RES_W-1:0] W1 = 22'h25A3C1;
    localparam logic [RES_W-1:0] W2 = 22'h1C0F3A;

    always #4 clk = ~clk;

    adc_serial_slave #(.RES_W(RES_W), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .conv_word(conv_word), .sdo(sdo), .act_chan(act_chan),
        .act_cfg(act_cfg), .int_clk_sel(int_clk_sel)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic shift_frame(input int nfall, input logic [23:0] din,
                               output logic [23:0] dout);
        dout = '0;
        cs_n = 1'b0;
        wait_n(3);
        for (int i = 0; i < nfall; i++) begin
            sdi = din[23-i];
            wait_n(2);
            dout[23-i] = sdo;
            sck = 1'b1;
            wait_n(4);
            sck = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic wait_conv();
        wait_n(CONV + 20);
    endtask

    task automatic t_reset();
        wait_n(2);
        check("R1", "sdo floats", {31'b0, sdo}, {31'b0, 1'bz});
        check("R1", "chan", {24'b0, act_chan}, 32'h0);
        check("R1", "cfg", {24'b0, act_cfg}, 32'h0);
        check("R1", "int flag", {31'b0, int_clk_sel}, 32'h0);
        cs_n = 1'b0;
        wait_n(3);
        check("R2", "busy sdo", {31'b0, sdo}, 32'h1);
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b1; sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4);
        end
        check("R11", "flag after low-sck select", {31'b0, int_clk_sel}, 32'h0);
        cs_n = 1'b1;
        wait_n(2);
        check("R2", "sdo floats deselected", {31'b0, sdo}, {31'b0, 1'bz});
    endtask

    task automatic t_full();
        logic [23:0] dout;
        wait_conv();
        cs_n = 1'b0; wait_n(3);
        check("R3", "sleep sdo", {31'b0, sdo}, 32'h0);
        shift_frame(24, {16'hA35C, 8'h0F}, dout);
        check("R4", "frame data (R12 sck in conv ignored)", {8'b0, dout}, {8'b0, 2'b00, W1});
        wait_n(2);
        check("R6", "sdo after 24th fall", {31'b0, sdo}, 32'h1);
        check("R5", "chan committed", {24'b0, act_chan}, 32'hA3);
        check("R6", "cfg committed", {24'b0, act_cfg}, 32'h5C);
        wait_n(CONV - 15);
        check("R3", "still converting", {31'b0, sdo}, 32'h1);
        wait_n(25);
        check("R3", "conversion done", {31'b0, sdo}, 32'h0);
        cs_n = 1'b1;
        wait_n(4);
    endtask

    task automatic t_held_invalid();
        logic [23:0] dout;
        conv_word = W2;
        for (int i = 0; i < 3; i++) begin
            cs_n = 1'b0; wait_n(5); cs_n = 1'b1; wait_n(5);
        end
        shift_frame(24, {16'h635C, 8'hAA}, dout);
        check("R3", "held result", {8'b0, dout}, {8'b0, 2'b00, W1});
        cs_n = 1'b1; wait_n(2);
        check("R10", "bad prefix chan", {24'b0, act_chan}, 32'hA3);
        check("R10", "bad prefix cfg", {24'b0, act_cfg}, 32'h5C);
    endtask

    task automatic t_en_off();
        logic [23:0] dout;
        wait_conv();
        shift_frame(24, {16'h8511, 8'h00}, dout);
        cs_n = 1'b1; wait_n(2);
        check("R4", "second result", {8'b0, dout}, {8'b0, 2'b00, W2});
        check("R10", "enable low chan", {24'b0, act_chan}, 32'hA3);
        check("R10", "enable low cfg", {24'b0, act_cfg}, 32'h5C);
    endtask

    task automatic t_abort(input int nfall, input logic [15:0] cmd,
                           input logic [7:0] exp_chan, input logic [7:0] exp_cfg,
                           input string req);
        logic [23:0] dout;
        wait_conv();
        shift_frame(nfall, {cmd, 8'h00}, dout);
        cs_n = 1'b1;
        wait_n(2);
        check("R2", "abort deselected", {31'b0, sdo}, {31'b0, 1'bz});
        cs_n = 1'b0;
        wait_n(3);
        check("R7", "abort starts conversion", {31'b0, sdo}, 32'h1);
        cs_n = 1'b1;
        wait_n(2);
        check(req, "abort chan", {24'b0, act_chan}, {24'b0, exp_chan});
        check(req, "abort cfg", {24'b0, act_cfg}, {24'b0, exp_cfg});
    endtask

    task automatic t_busy_sck();
        logic [23:0] dout;
        cs_n = 1'b0; wait_n(3);
        for (int i = 0; i < 8; i++) begin
            sdi = 1'b1; sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4);
        end
        cs_n = 1'b1;
        wait_conv();
        shift_frame(24, 24'h0, dout);
        cs_n = 1'b1; wait_n(2);
        check("R12", "no shift while converting", {8'b0, dout}, {8'b0, 2'b00, W2});
        check("R12", "chan untouched", {24'b0, act_chan}, 32'hBE);
        check("R12", "cfg untouched", {24'b0, act_cfg}, 32'h66);
    endtask

    task automatic t_mode();
        wait_conv();
        sck = 1'b1; wait_n(3);
        cs_n = 1'b0; wait_n(3);
        check("R11", "high sck sets flag", {31'b0, int_clk_sel}, 32'h1);
        cs_n = 1'b1; wait_n(2);
        sck = 1'b0; wait_n(3);
        cs_n = 1'b0; wait_n(3);
        check("R11", "low sck clears flag", {31'b0, int_clk_sel}, 32'h0);
        check("R3", "still asleep", {31'b0, sdo}, 32'h0);
        cs_n = 1'b1; wait_n(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        t_reset();
        t_full();
        t_held_invalid();
        t_en_off();
        t_abort(7,  16'hB122, 8'hA3, 8'h5C, "R7");
        t_abort(8,  16'hB433, 8'hB4, 8'h5C, "R8");
        t_abort(15, 16'hA744, 8'hA7, 8'h5C, "R8");
        t_abort(16, 16'hBE66, 8'hBE, 8'h66, "R9");
        t_busy_sck();
        t_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule